// File: doc/BRIEF.md
# Peripheral Interrupt Priority Arbiter

This block ranks four peripheral interrupt requests and presents one of them to the CPU. The four requests are DMA channel 0, DMA channel 1, a watchdog request and a bus-controller request. The requests form two groups: the two DMA channels, and the watchdog with the bus controller. One 16-bit configuration register holds a 4-bit priority level for each group. Every clock edge the block samples the requests. It picks a winner inside each group by fixed order, then picks between the groups by level. It raises the interrupt only when the winning level is above a 4-bit CPU mask.

Software writes the configuration register through a single-cycle write strobe and can read it back at any time. A power-on reset or a manual reset clears the register. Standby mode keeps the register contents and blocks writes. The request, mask and result pins are plain level signals. They have no handshake, because the result is recomputed on every edge and nothing is queued.

Top module: `irq_prio_arb`

## Requirements
- R1: While either `por_n` or `mres_n` is low, the configuration register reads 0x0000 and `irq_o`, `irq_level` and `irq_src` are all zero.
- R2: While `standby` is high, a write strobe is ignored and the register keeps its value.
- R3: Bits 15:12 and 3:0 of `cfg_rdata` always read as zero, whatever value is written to them.
- R4: A write with `cfg_we` high and `standby` low stores `cfg_wdata[11:8]` as the DMA group level and `cfg_wdata[7:4]` as the timer group level. The new value is visible on `cfg_rdata` after that clock edge.
- R5: The outputs are registered. After each edge they reflect the requests, mask and configuration present just before that edge. `irq_src` encodes 0 for DMA channel 0, 1 for DMA channel 1, 2 for the watchdog and 3 for the bus controller, and `irq_level` carries the winner's level.
- R6: When both DMA channels request together, DMA channel 0 is chosen.
- R7: When the watchdog and the bus controller request together, the watchdog is chosen.
- R8: A group whose level is 0 never raises `irq_o`, and it does not block the other group.
- R9: `irq_o` is high only when the winning level is strictly greater than `cpu_mask`. When `irq_o` is low, `irq_level` and `irq_src` are zero.
- R10: Between the groups, the higher level wins. When both groups have the same nonzero level, the DMA group wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mres_n | input | 1 | Manual reset, active low, asynchronous |
| standby | input | 1 | Standby mode; blocks register writes |
| cfg_we | input | 1 | Single-cycle write strobe |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Register read value, reserved bits zero |
| req_dma0 | input | 1 | DMA channel 0 request |
| req_dma1 | input | 1 | DMA channel 1 request |
| req_wdt | input | 1 | Watchdog request |
| req_bus | input | 1 | Bus-controller request |
| cpu_mask | input | 4 | CPU interrupt mask level |
| irq_o | output | 1 | Registered interrupt to the CPU |
| irq_level | output | 4 | Registered level of the winner |
| irq_src | output | 2 | Registered source code of the winner |

## Verification
A register write and an arbitration decision can fall in the same cycle. The decision at that edge must use the old levels, and the new levels apply only from the next edge. The bench provokes this by issuing random writes, including writes during standby, in the same cycles as random requests and masks. It predicts each cycle's outputs from the configuration held before the edge. Directed cases add same-level ties inside a group and across groups, zero levels, and masks equal to and one below the winning level.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  localparam int SRC_W = 2;
  localparam int CFG_W = 16;
  localparam int DMA_LSB = 8;
  localparam int TMR_LSB = 4;
  localparam int N_GRP = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_DMA0 = 2'd0,
    SRC_DMA1 = 2'd1,
    SRC_WDT  = 2'd2,
    SRC_BUS  = 2'd3
  } src_e;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] lvl;
    logic [SRC_W-1:0] src;
  } cand_t;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
  import irq_arb_pkg::*;
#(
  parameter int W     = CFG_W,
  parameter int LW    = LVL_W,
  parameter int A_LSB = DMA_LSB,
  parameter int B_LSB = TMR_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [LW-1:0] lvl_a,
  output logic [LW-1:0] lvl_b
);
  localparam logic [W-1:0] KEEP = ({{(W-LW){1'b0}}, {LW{1'b1}}} << A_LSB)
                                | ({{(W-LW){1'b0}}, {LW{1'b1}}} << B_LSB);

  logic [LW-1:0] a_q, b_q;
  logic          wr_ok;

  assign wr_ok = we && !standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (wr_ok) begin
      a_q <= wdata[A_LSB +: LW];
      b_q <= wdata[B_LSB +: LW];
    end
  end

  always_comb begin
    rdata = '0;
    rdata[A_LSB +: LW] = a_q;
    rdata[B_LSB +: LW] = b_q;
  end

  assign lvl_a = a_q;
  assign lvl_b = b_q;

  AST_STANDBY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(rdata)); // R2
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !standby) |=> (rdata == ($past(wdata) & KEEP))); // R4
endmodule

// File: rtl/irq_pair_pick.sv
module irq_pair_pick
  import irq_arb_pkg::*;
#(
  parameter int                LW     = LVL_W,
  parameter logic [SRC_W-1:0]  CODE_HI = 2'd0,
  parameter logic [SRC_W-1:0]  CODE_LO = 2'd1
) (
  input  logic          req_hi,
  input  logic          req_lo,
  input  logic [LW-1:0] lvl,
  output cand_t         cand
);
  always_comb begin
    cand.hit = (req_hi || req_lo) && (lvl != '0);
    cand.lvl = lvl;
    cand.src = req_hi ? CODE_HI : CODE_LO;
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve
  import irq_arb_pkg::*;
#(
  parameter int LW = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cand_t            cand_a,
  input  cand_t            cand_b,
  input  logic [LW-1:0]    mask,
  output logic             irq_q,
  output logic [LW-1:0]    lvl_q,
  output logic [SRC_W-1:0] src_q
);
  cand_t win;
  logic  fire;

  always_comb begin
    win = cand_a;
    if (cand_b.hit && (!cand_a.hit || (cand_b.lvl > cand_a.lvl))) win = cand_b;
    fire = win.hit && (win.lvl > mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      src_q <= '0;
    end else if (fire) begin
      irq_q <= 1'b1;
      lvl_q <= win.lvl;
      src_q <= win.src;
    end else begin
      irq_q <= 1'b0;
      lvl_q <= '0;
      src_q <= '0;
    end
  end

  AST_FIRE_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (lvl_q > $past(mask))); // R9
  AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (lvl_q != '0)); // R8
  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_q |-> (lvl_q == '0 && src_q == '0)); // R9
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
(
  input  logic        clk,
  input  logic        por_n,
  input  logic        mres_n,
  input  logic        standby,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        req_dma0,
  input  logic        req_dma1,
  input  logic        req_wdt,
  input  logic        req_bus,
  input  logic [3:0]  cpu_mask,
  output logic        irq_o,
  output logic [3:0]  irq_level,
  output logic [1:0]  irq_src
);
  localparam int NREQ = 2 * N_GRP;

  logic             rst_n;
  logic [NREQ-1:0]  req_vec;
  logic [LVL_W-1:0] grp_lvl [N_GRP];
  cand_t            grp_cand [N_GRP];

  assign rst_n   = por_n & mres_n;
  assign req_vec = {req_bus, req_wdt, req_dma1, req_dma0};

  irq_cfg_reg #(
    .W(CFG_W), .LW(LVL_W), .A_LSB(DMA_LSB), .B_LSB(TMR_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .standby(standby), .we(cfg_we),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .lvl_a(grp_lvl[0]), .lvl_b(grp_lvl[1])
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    irq_pair_pick #(
      .LW(LVL_W),
      .CODE_HI(SRC_W'(2 * g)),
      .CODE_LO(SRC_W'(2 * g + 1))
    ) u_pick (
      .req_hi(req_vec[2*g]),
      .req_lo(req_vec[2*g+1]),
      .lvl(grp_lvl[g]),
      .cand(grp_cand[g])
    );
  end

  irq_resolve #(.LW(LVL_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .cand_a(grp_cand[0]), .cand_b(grp_cand[1]),
    .mask(cpu_mask),
    .irq_q(irq_o), .lvl_q(irq_level), .src_q(irq_src)
  );

  AST_DMA0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src == SRC_DMA1) |-> !$past(req_dma0)); // R6
  AST_WDT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src == SRC_BUS) |-> !$past(req_wdt)); // R7
  AST_DMA_TIE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_src[1]) |-> !(($past(req_dma0) || $past(req_dma1))
                               && $past(cfg_rdata[11:8]) >= irq_level)); // R10
endmodule

// File: tb/irq_prio_arb_tb.sv
`timescale 1ns/1ps
module irq_prio_arb_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, mres_n = 1'b1, standby = 1'b0, cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_dma0 = 0, req_dma1 = 0, req_wdt = 0, req_bus = 0;
  logic [3:0]  cpu_mask = '0;
  logic        irq_o;
  logic [3:0]  irq_level;
  logic [1:0]  irq_src;

  int n_run = 0, n_fail = 0;
  logic [15:0] shadow = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb u_dut (
    .clk(clk), .por_n(por_n), .mres_n(mres_n), .standby(standby),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_dma0(req_dma0), .req_dma1(req_dma1), .req_wdt(req_wdt), .req_bus(req_bus),
    .cpu_mask(cpu_mask), .irq_o(irq_o), .irq_level(irq_level), .irq_src(irq_src)
  );

  function automatic logic [6:0] model(logic [15:0] cfg, logic [3:0] rq, logic [3:0] m);
    logic [3:0] dl, tl, wl;
    logic dh, th, wh;
    logic [1:0] ws;
    dl = cfg[11:8];
    tl = cfg[7:4];
    dh = (rq[0] | rq[1]) && dl != 0;
    th = (rq[2] | rq[3]) && tl != 0;
    if (dh && (!th || dl >= tl)) begin wh = 1; wl = dl; ws = rq[0] ? 2'd0 : 2'd1; end
    else if (th) begin wh = 1; wl = tl; ws = rq[2] ? 2'd2 : 2'd3; end
    else begin wh = 0; wl = 0; ws = 0; end
    if (wh && wl > m) return {1'b1, wl, ws};
    return 7'd0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Call just after a falling edge; checks land at the next falling edge.
  task automatic step(bit we, logic [15:0] wd, bit sb, logic [3:0] rq, logic [3:0] m, string tag);
    logic [6:0] exp;
    string rtag;
    cfg_we = we; cfg_wdata = wd; standby = sb;
    {req_bus, req_wdt, req_dma1, req_dma0} = rq;
    cpu_mask = m;
    exp = model(shadow, rq, m);
    rtag = (we && sb) ? "R2" : (we ? "R3/R4" : "R4");
    if (we && !sb) shadow = wd & 16'h0FF0;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {9'd0, irq_o, irq_level, irq_src}, {9'd0, exp});
    chk(rtag, cfg_rdata, shadow);
    cfg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    chk("R1 por", cfg_rdata, 16'h0000);
    chk("R1 por out", {9'd0, irq_o, irq_level, irq_src}, 16'h0000);
    por_n = 1'b1;
    @(negedge clk);

    step(1, 16'hFFFF, 0, 4'b0000, 0, "R3");
    step(1, 16'h0A50, 0, 4'b0011, 0, "R6");
    step(0, 16'h0000, 0, 4'b1100, 0, "R7");
    step(0, 16'h0000, 0, 4'b1010, 0, "R10");
    step(0, 16'h0000, 0, 4'b0001, 4'd10, "R9");
    step(0, 16'h0000, 0, 4'b0001, 4'd9, "R9");
    step(0, 16'h0000, 0, 4'b0100, 4'd5, "R9");
    step(1, 16'h0770, 0, 4'b1111, 0, "R5");
    step(0, 16'h0000, 0, 4'b1111, 0, "R10");
    step(0, 16'h0000, 0, 4'b0110, 0, "R10");
    step(1, 16'h0050, 0, 4'b0000, 0, "R4");
    step(0, 16'h0000, 0, 4'b0011, 0, "R8");
    step(0, 16'h0000, 0, 4'b1011, 0, "R8");
    step(1, 16'h0F00, 1, 4'b1000, 0, "R2");
    step(0, 16'h0000, 1, 4'b0001, 0, "R8");

    for (int i = 0; i < 500; i++) begin
      bit we, sb;
      we = ($urandom % 4) == 0;
      sb = ($urandom % 5) == 0;
      step(we, 16'($urandom), sb, 4'($urandom), 4'($urandom % 8), "R5");
    end

    step(1, 16'h0CC0, 0, 4'b1111, 0, "R10");
    @(negedge clk);
    mres_n = 1'b0;
    @(negedge clk);
    shadow = '0;
    chk("R1 mres", cfg_rdata, 16'h0000);
    chk("R1 mres out", {9'd0, irq_o, irq_level, irq_src}, 16'h0000);
    mres_n = 1'b1;
    @(negedge clk);
    step(0, 16'h0000, 0, 4'b1111, 0, "R1");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule